// File: doc/BRIEF.md
# Pushbutton Power Sequencing Controller

This block is the control state machine that decides when two supply rails of a portable system are switched on: a linear rail that stays on whenever the system is alive, and a switching rail that carries the main load. It reacts to an active-low pushbutton, an enable line driven by a host processor, a flag saying external supply is valid, a battery-present flag, a flag saying the output rail is above its undervoltage limit, and a power-on-reset pulse. It drives the two rail enables and exposes its present state as a 3-bit code.

All timing is counted in ticks of a millisecond strobe supplied from outside, and every duration is a parameter. These durations are the button qualification time, the supply settling time, the power-up window, the hard-reset hold time and the power-down lockout. There are two power-up paths: one from hard reset and one from the off state. During the power-up window both paths ignore the host enable, and at the end of the window the host enable decides whether the system stays on. A long hold of the button forces a hard reset, but only if the press began while the system was powering up or on. Every input arrives as a clean flag synchronous to the clock.

Top module: `pb_power_seq`

## Requirements
- R1: While `rst_n` is low and right after it is released, `state_o` is 0 (hard reset) and both rail enables are low. State codes are: 0 hard reset, 1 button power-up, 2 supply power-up, 3 on, 4 forced power-down, 5 host power-down, 6 off.
- R2: In state 0, a button held low for `T_PRESS` consecutive ticks moves to state 1 on the `T_PRESS`-th tick. A release before that restarts the count.
- R3: In state 1 the linear rail is enabled from the first cycle. The switching rail is enabled only after the first tick counted in that state.
- R4: In state 6, `ext_ok` held for `T_SUPPLY` ticks, or the button held for `T_PRESS` ticks, moves to state 2. In state 2 both rails are enabled.
- R5: In states 1 and 2 the state changes only on a tick. The host enable is ignored until the `T_WINDOW`-th tick. On that tick the next state is 3 if `host_en` is high, and 6 (switching rail off) if it is low.
- R6: In state 0, `host_en` and `vout_ok` both high move to state 3 on the next clock, with both rails enabled together. With `vout_ok` low the block stays in state 0.
- R7: In state 6, `host_en` high with the button released moves to state 3 on the next clock.
- R8: In state 3, `host_en` low moves to state 5. State 5 ignores the button, `host_en` and `ext_ok`, and moves to state 6 on its `T_LOCK`-th tick.
- R9: A button press that began in state 1, 2 or 3 and is held for `T_HOLD` ticks moves to state 4 once the block is in state 3, 5 or 6. A press that began in any other state never causes this.
- R10: State 4 moves on its `T_LOCK`-th tick to state 1 if `ext_ok` is high, and to state 0 otherwise.
- R11: `por` high while `bat_present` is low moves to state 4 on the next clock from any state. `por` with a battery present has no effect.
- R12: The linear rail is enabled in states 1, 2, 3, 5 and 6. The switching rail is enabled only in states 2 and 3, and in state 1 after its first tick. Both rails are off in states 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| btn_n | input | 1 | Pushbutton, low when pressed |
| host_en | input | 1 | Host request to keep the switching rail on |
| ext_ok | input | 1 | External supply valid |
| bat_present | input | 1 | Battery connected |
| vout_ok | input | 1 | Output rail above undervoltage limit |
| por | input | 1 | Power-on-reset pulse |
| lin_en | output | 1 | Linear rail enable |
| sw_en | output | 1 | Switching rail enable |
| state_o | output | 3 | Present state code |

## Verification
The bound assertions watch, on every cycle, the relations that can be seen at the ports in a single step. These are: the rail map and the rule that the switching rail is never on without the linear rail; the immediate moves from hard reset and from off when the host enable is raised; the jump to forced power-down on a reset pulse without a battery; the fact that the power-up states change only on a tick; and the fact that the host lockout can only exit to off or forced power-down. The tick-counted windows need directed scenarios in the bench: the press qualification and its restart, the power-up window and its host decision, the lockout length, and whether a long press qualifies depending on the state it began in.

// File: rtl/pb_power_seq.sv
module pb_power_seq #(
  parameter int T_PRESS  = 400,
  parameter int T_SUPPLY = 100,
  parameter int T_WINDOW = 5000,
  parameter int T_HOLD   = 14000,
  parameter int T_LOCK   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       btn_n,
  input  logic       host_en,
  input  logic       ext_ok,
  input  logic       bat_present,
  input  logic       vout_ok,
  input  logic       por,
  output logic       lin_en,
  output logic       sw_en,
  output logic [2:0] state_o
);
  localparam int M1   = (T_PRESS > T_SUPPLY) ? T_PRESS : T_SUPPLY;
  localparam int M2   = (T_WINDOW > T_LOCK) ? T_WINDOW : T_LOCK;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M3 > T_HOLD) ? M3 : T_HOLD;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {
    S_HR = 3'd0, S_PUP1 = 3'd1, S_PUP2 = 3'd2, S_ON = 3'd3,
    S_PDN1 = 3'd4, S_PDN2 = 3'd5, S_OFF = 3'd6
  } st_t;

  st_t st, nx;
  logic [CW-1:0] st_cnt, btn_cnt, sup_cnt, hold_cnt;
  logic btn_q, hold_qual;

  wire pressed     = !btn_n;
  wire press_start = pressed && !btn_q;
  wire cold_por    = por && !bat_present;

  wire lock_done = ms_tick && (st_cnt == CW'(T_LOCK - 1));
  wire win_done  = ms_tick && (st_cnt == CW'(T_WINDOW - 1));
  wire btn_done  = pressed && ms_tick && (btn_cnt == CW'(T_PRESS - 1));
  wire sup_done  = ext_ok && ms_tick && (sup_cnt == CW'(T_SUPPLY - 1));
  wire hold_hit  = hold_qual && pressed &&
                   ((hold_cnt == CW'(T_HOLD)) ||
                    (ms_tick && hold_cnt == CW'(T_HOLD - 1)));
  wire hold_used = hold_hit && (st == S_ON || st == S_PDN2 || st == S_OFF);

  always_comb begin
    nx = st;
    if (cold_por) nx = S_PDN1;
    else begin
      case (st)
        S_HR:   if (host_en && vout_ok) nx = S_ON;
                else if (btn_done || sup_done) nx = S_PUP1;
        S_PUP1,
        S_PUP2: if (win_done) nx = host_en ? S_ON : S_OFF;
        S_ON:   if (hold_hit) nx = S_PDN1;
                else if (!host_en) nx = S_PDN2;
        S_PDN1: if (lock_done) nx = ext_ok ? S_PUP1 : S_HR;
        S_PDN2: if (hold_hit) nx = S_PDN1;
                else if (lock_done) nx = S_OFF;
        S_OFF:  if (hold_hit) nx = S_PDN1;
                else if (host_en) nx = S_ON;
                else if (btn_done || sup_done) nx = S_PUP2;
        default: nx = S_HR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_HR;
      st_cnt  <= '0;
      btn_cnt <= '0;
      sup_cnt <= '0;
      btn_q   <= 1'b0;
    end else begin
      st    <= nx;
      btn_q <= pressed;
      if (nx != st) st_cnt <= '0;
      else if (ms_tick && st_cnt != CW'(TMAX)) st_cnt <= st_cnt + 1'b1;
      if (!pressed || nx != st) btn_cnt <= '0;
      else if (ms_tick && btn_cnt != CW'(TMAX)) btn_cnt <= btn_cnt + 1'b1;
      if (!ext_ok || nx != st) sup_cnt <= '0;
      else if (ms_tick && sup_cnt != CW'(TMAX)) sup_cnt <= sup_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_qual <= 1'b0;
      hold_cnt  <= '0;
    end else if (!pressed || hold_used) begin
      hold_qual <= 1'b0;
      hold_cnt  <= '0;
    end else if (press_start) begin
      hold_qual <= (st == S_PUP1 || st == S_PUP2 || st == S_ON);
      hold_cnt  <= '0;
    end else if (hold_qual && ms_tick && hold_cnt != CW'(T_HOLD)) begin
      hold_cnt <= hold_cnt + 1'b1;
    end
  end

  assign lin_en  = (st != S_HR) && (st != S_PDN1);
  assign sw_en   = (st == S_PUP2) || (st == S_ON) || (st == S_PUP1 && st_cnt != '0);
  assign state_o = st;
endmodule

module pb_power_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       btn_n,
  input logic       host_en,
  input logic       vout_ok,
  input logic       bat_present,
  input logic       por,
  input logic       lin_en,
  input logic       sw_en,
  input logic [2:0] state_o
);
  wire cold = por && !bat_present;

  // R12
  sw_needs_lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> lin_en);

  // R12
  rails_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 || state_o == 3'd4) |-> (!lin_en && !sw_en));

  // R11
  cold_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> state_o == 3'd4);

  // R6
  hr_direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && host_en && vout_ok && !cold) |=> state_o == 3'd3);

  // R7
  off_direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6 && host_en && btn_n && !cold) |=> state_o == 3'd3);

  // R5
  window_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd1 || state_o == 3'd2) && !ms_tick && !cold) |=> $stable(state_o));

  // R8
  lockout_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && !cold) |=> (state_o == 3'd5 || state_o == 3'd6 || state_o == 3'd4));
endmodule

bind pb_power_seq pb_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_n(btn_n),
  .host_en(host_en), .vout_ok(vout_ok), .bat_present(bat_present),
  .por(por), .lin_en(lin_en), .sw_en(sw_en), .state_o(state_o)
);

// File: tb/pb_power_seq_test.sv
module pb_power_seq_test;
  localparam int TP = 4, TS = 3, TW = 10, TH = 20, TL = 5;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, btn_n = 1'b1, host_en = 1'b0;
  logic ext_ok = 1'b0, bat_present = 1'b1, vout_ok = 1'b0, por = 1'b0;
  logic lin_en, sw_en;
  logic [2:0] state_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pb_power_seq #(.T_PRESS(TP), .T_SUPPLY(TS), .T_WINDOW(TW), .T_HOLD(TH), .T_LOCK(TL)) uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .btn_n(btn_n), .host_en(host_en),
    .ext_ok(ext_ok), .bat_present(bat_present), .vout_ok(vout_ok), .por(por),
    .lin_en(lin_en), .sw_en(sw_en), .state_o(state_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic rails(string req, int l, int s);
    check({req, " lin"}, lin_en, l);
    check({req, " sw"}, sw_en, s);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 state in reset", state_o, 0);
    rails("R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state after reset", state_o, 0);
    rails("R1 after reset", 0, 0);
  endtask

  task automatic t_press_powerup;
    btn_n = 1'b0;
    ticks(TP - 1);
    check("R2 short press stays", state_o, 0);
    btn_n = 1'b1;
    ticks(2);
    btn_n = 1'b0;
    ticks(TP - 1);
    check("R2 restarted count", state_o, 0);
    ticks(1);
    check("R2 press enters PUP1", state_o, 1);
    rails("R3 PUP1 first", 1, 0);
    btn_n = 1'b1;
    ticks(1);
    rails("R3 PUP1 after tick", 1, 1);
    host_en = 1'b1;
    ticks(3);
    host_en = 1'b0;
    ticks(TW - 5);
    check("R5 host ignored in window", state_o, 1);
    host_en = 1'b1;
    ticks(1);
    check("R5 window end to on", state_o, 3);
    rails("R12 on", 1, 1);
  endtask

  task automatic t_lockout_and_supply;
    host_en = 1'b0;
    @(negedge clk);
    check("R8 host low enters PDN2", state_o, 5);
    rails("R12 PDN2", 1, 0);
    btn_n = 1'b0; host_en = 1'b1; ext_ok = 1'b1;
    ticks(TL - 1);
    check("R8 inputs ignored in lockout", state_o, 5);
    btn_n = 1'b1; host_en = 1'b0; ext_ok = 1'b0;
    ticks(1);
    check("R8 lockout ends in off", state_o, 6);
    rails("R12 off", 1, 0);
    ext_ok = 1'b1;
    ticks(TS - 1);
    check("R4 supply not yet settled", state_o, 6);
    ticks(1);
    check("R4 supply enters PUP2", state_o, 2);
    rails("R4 PUP2", 1, 1);
    ext_ok = 1'b0;
    ticks(TW - 1);
    check("R5 PUP2 before window end", state_o, 2);
    ticks(1);
    check("R5 window end host low to off", state_o, 6);
    rails("R5 switching rail dropped", 1, 0);
  endtask

  task automatic t_off_host_and_hold;
    host_en = 1'b1;
    @(negedge clk);
    check("R7 off host high to on", state_o, 3);
    btn_n = 1'b0;
    ticks(TH - 1);
    check("R9 hold not complete", state_o, 3);
    ticks(1);
    check("R9 qualified hold to PDN1", state_o, 4);
    rails("R12 PDN1", 0, 0);
    btn_n = 1'b1; host_en = 1'b0;
    ticks(TL - 1);
    check("R10 PDN1 waiting", state_o, 4);
    ticks(1);
    check("R10 PDN1 to HR", state_o, 0);
  endtask

  task automatic t_hr_host_and_unqualified_hold;
    host_en = 1'b1;
    ticks(2);
    check("R6 waits for vout_ok", state_o, 0);
    vout_ok = 1'b1;
    @(negedge clk);
    check("R6 HR direct to on", state_o, 3);
    rails("R6 both rails together", 1, 1);
    host_en = 1'b0;
    @(negedge clk);
    ticks(TL);
    check("R8 back to off", state_o, 6);
    btn_n = 1'b0;
    ticks(TP);
    check("R4 button in off to PUP2", state_o, 2);
    host_en = 1'b1;
    ticks(TW);
    check("R5 PUP2 window to on", state_o, 3);
    ticks(8);
    check("R9 press begun in off never resets", state_o, 3);
    btn_n = 1'b1;
  endtask

  task automatic t_por;
    @(negedge clk) por = 1'b1;
    @(negedge clk) por = 1'b0;
    @(negedge clk);
    check("R11 por with battery ignored", state_o, 3);
    bat_present = 1'b0; por = 1'b1;
    @(negedge clk) por = 1'b0;
    check("R11 cold por to PDN1", state_o, 4);
    bat_present = 1'b1;
    ext_ok = 1'b1;
    ticks(TL - 1);
    check("R10 PDN1 holding", state_o, 4);
    ticks(1);
    check("R10 supply present to PUP1", state_o, 1);
    ext_ok = 1'b0; host_en = 1'b0;
    ticks(TW);
    check("R5 PUP1 window host low to off", state_o, 6);
  endtask

  initial begin
    t_reset();
    t_press_powerup();
    t_lockout_and_supply();
    t_off_host_and_hold();
    t_hr_host_and_unqualified_hold();
    t_por();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule